// File: doc/BRIEF.md
# SDRAM Bank Remapping Address Translator

This block sits on the access path between the internal bus and the external memory controller. Each access carries an address made of a bank field in the top bits and a row/column field below it. The block looks up a bank code in a per-page table and puts that code in the bank field. The table is indexed by the upper bits of the row/column field, which form the page number. The row and column bits are not changed. The table is filled offline so that pages often visited one after another end up in different banks, which cuts page misses.

Software loads the table through a simple write port, one entry per cycle, and then gives a commit pulse. Until that commit, and whenever the bypass input is high, the original bank bits pass through unchanged. The lookup costs one registered cycle. The valid flag, the read/write flag and the data word are delayed by the same cycle so that they stay aligned with the translated address. With the defaults, the address is 24 bits: bank in bits [23:22] and row/column in [21:0]. The page index is the top PAGE_W bits of the row/column field, bits [21:12] by default. The full 16 MB part uses PAGE_W = 14, which indexes bits [21:8] and gives a 4 KB table of 2-bit entries.

Top module: `bank_remap`

## Requirements
- R1: While reset is asserted and on the first edge after it, out_valid is 0. After reset the block is in pass-through mode until a commit is seen.
- R2: When remapping is active and bypass_req is 0, the bank field out_addr[23:22] equals the table entry at page in_addr[21:22-PAGE_W] of the access.
- R3: The row/column field out_addr[21:0] always equals in_addr[21:0] of the same access.
- R4: Every access appears on the outputs exactly one clock after it is presented. out_write and out_data carry that access's in_write and in_data. A cycle with in_valid at 0 gives out_valid at 0 one clock later.
- R5: While bypass_req is 1, or before any commit, the bank field is copied unchanged from in_addr[23:22].
- R6: A table write with tbl_we at 1 stores tbl_bank at entry tbl_idx, and later lookups see it. A lookup of the same entry in the same cycle as the write returns the previous contents.
- R7: A one-cycle tbl_commit turns remapping on for accesses presented from the next cycle onward. Remapping stays on until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Access present this cycle |
| in_write | input | 1 | Access is a write (1) or a read (0) |
| in_addr | input | BANK_W+RC_W | Untranslated address: bank field on top, row/column below |
| in_data | input | DATA_W | Write data of the access |
| bypass_req | input | 1 | Forces the original bank bits through |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | PAGE_W | Page index of the entry being written |
| tbl_bank | input | BANK_W | Bank code to store |
| tbl_commit | input | 1 | Marks the table valid and enables remapping |
| out_valid | output | 1 | Translated access present |
| out_write | output | 1 | Delayed read/write flag |
| out_addr | output | BANK_W+RC_W | Translated address |
| out_data | output | DATA_W | Delayed write data |

## Verification
On every cycle, the inline assertions check the one-cycle alignment of valid, direction and data. They also check that the row/column bits pass through unchanged, that the bank is copied while bypass or pre-commit mode holds, and that out_valid is low after reset. The actual table contents are shown only by the bench's scenarios. These cover the bank code delivered for each programmed page, the old-value result when a write and a lookup hit the same entry together, the exact cycle at which a commit takes effect, and the return to pass-through after a mid-run reset. The scoreboard predicts each of these from its own shadow copy of the table.

// File: rtl/bank_remap.sv
module bank_remap #(
  parameter int BANK_W = 2,
  parameter int RC_W   = 22,
  parameter int PAGE_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_write,
  input  logic [BANK_W+RC_W-1:0]   in_addr,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     bypass_req,
  input  logic                     tbl_we,
  input  logic [PAGE_W-1:0]        tbl_idx,
  input  logic [BANK_W-1:0]        tbl_bank,
  input  logic                     tbl_commit,
  output logic                     out_valid,
  output logic                     out_write,
  output logic [BANK_W+RC_W-1:0]   out_addr,
  output logic [DATA_W-1:0]        out_data
);
  localparam int AW    = BANK_W + RC_W;
  localparam int DEPTH = 1 << PAGE_W;

  logic [BANK_W-1:0] map_q [DEPTH];
  logic              remap_on;

  wire [PAGE_W-1:0] page     = in_addr[RC_W-1 -: PAGE_W];
  wire [BANK_W-1:0] old_bank = in_addr[AW-1 -: BANK_W];
  wire              use_map  = remap_on && !bypass_req;
  wire [BANK_W-1:0] new_bank = use_map ? map_q[page] : old_bank;

  always_ff @(posedge clk)
    if (tbl_we) map_q[tbl_idx] <= tbl_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_on  <= 1'b0;
      out_valid <= 1'b0;
      out_write <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      if (tbl_commit) remap_on <= 1'b1;
      out_valid <= in_valid;
      if (in_valid) begin
        out_write <= in_write;
        out_addr  <= {new_bank, in_addr[RC_W-1:0]};
        out_data  <= in_data;
      end
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_rc_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_addr[RC_W-1:0] == $past(in_addr[RC_W-1:0]));

  assert_valid_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_fields_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_write == $past(in_write)) && (out_data == $past(in_data)));

  assert_bypass_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (bypass_req || !remap_on)) |=>
      out_addr[AW-1 -: BANK_W] == $past(in_addr[AW-1 -: BANK_W]));

  assert_commit_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    remap_on |=> remap_on);
endmodule

// File: tb/sim_bank_remap.sv
module sim_bank_remap;
  localparam int BANK_W = 2, RC_W = 22, PAGE_W = 10, DATA_W = 32;
  localparam int AW = BANK_W + RC_W;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_write = 0, bypass_req = 0, tbl_we = 0, tbl_commit = 0;
  logic [AW-1:0] in_addr = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [PAGE_W-1:0] tbl_idx = '0;
  logic [BANK_W-1:0] tbl_bank = '0;
  logic out_valid, out_write;
  logic [AW-1:0] out_addr;
  logic [DATA_W-1:0] out_data;

  bank_remap #(.BANK_W(BANK_W), .RC_W(RC_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_write(in_write),
    .in_addr(in_addr), .in_data(in_data), .bypass_req(bypass_req),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_bank(tbl_bank), .tbl_commit(tbl_commit),
    .out_valid(out_valid), .out_write(out_write), .out_addr(out_addr), .out_data(out_data));

  always #4 clk = ~clk;

  typedef struct {
    logic w;
    logic [AW-1:0] a;
    logic [DATA_W-1:0] d;
    string tag;
  } exp_t;

  exp_t q[$];
  logic [BANK_W-1:0] shadow [1 << PAGE_W];
  bit mode = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [AW-1:0] mk(input logic [1:0] b, input int pg, input logic [11:0] col);
    return {b, pg[PAGE_W-1:0], col};
  endfunction

  task automatic step(input bit acc, input bit w, input logic [AW-1:0] a,
                      input logic [DATA_W-1:0] d, input bit twe, input int ti,
                      input logic [BANK_W-1:0] tb, input bit cm, input string tag);
    exp_t e;
    logic [BANK_W-1:0] b;
    int pg;
    in_valid = acc; in_write = w; in_addr = a; in_data = d;
    tbl_we = twe; tbl_idx = ti[PAGE_W-1:0]; tbl_bank = tb; tbl_commit = cm;
    if (acc) begin
      pg = int'(a[RC_W-1 -: PAGE_W]);
      b = (mode && !bypass_req) ? shadow[pg] : a[AW-1 -: BANK_W];
      e.w = w; e.a = {b, a[RC_W-1:0]}; e.d = d; e.tag = tag;
      q.push_back(e);
    end
    if (twe) shadow[ti] = tb;
    if (cm) mode = 1;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, '0, '0, 0, 0, '0, 0, "");
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected output addr %h exp none", out_addr);
      end else begin
        e = q.pop_front();
        if (out_addr !== e.a || out_write !== e.w || out_data !== e.d) begin
          errors++;
          $display("FAIL %s got a=%h w=%b d=%h exp a=%h w=%b d=%h",
                   e.tag, out_addr, out_write, out_data, e.a, e.w, e.d);
        end
      end
    end
  end

  task automatic chk_idle(input string tag);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s out_valid got %b exp 0", tag, out_valid);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; mode = 0;
    in_valid = 0; tbl_we = 0; tbl_commit = 0;
    @(negedge clk);
    chk_idle("R1 reset");
    @(negedge clk);
    chk_idle("R1 reset");
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (shadow[i]) shadow[i] = '0;
    @(negedge clk);
    do_reset();
    chk_idle("R1 after reset");

    // R5/R1: table written but not committed -> pass-through
    step(0, 0, '0, '0, 1, 5, 2'd3, 0, "");
    step(1, 0, mk(2'd0, 5, 12'h123), 32'h1111_0000, 0, 0, '0, 0, "R5 precommit");
    step(1, 1, mk(2'd1, 5, 12'h0), 32'h1111_0001, 0, 0, '0, 0, "R1 passthru");

    // program a row of pages with codes 2,0,1,3 and commit (R6 load, R7)
    step(0, 0, '0, '0, 1, 8, 2'd2, 0, "");
    step(0, 0, '0, '0, 1, 9, 2'd0, 0, "");
    step(0, 0, '0, '0, 1, 10, 2'd1, 0, "");
    // commit cycle: this access still passes through (R7)
    step(1, 0, mk(2'd3, 8, 12'h010), 32'hA0, 1, 11, 2'd3, 1, "R7 commit same cycle");
    step(1, 0, mk(2'd3, 8, 12'h010), 32'hA1, 0, 0, '0, 0, "R7 commit next cycle R2");
    step(1, 1, mk(2'd1, 9, 12'hFFF), 32'hDEAD_BEEF, 0, 0, '0, 0, "R2 page9");
    step(1, 0, mk(2'd0, 10, 12'h000), 32'h0, 0, 0, '0, 0, "R2 page10");
    step(1, 1, mk(2'd0, 11, 12'hABC), 32'h5555_AAAA, 0, 0, '0, 0, "R3 page11");
    step(1, 0, mk(2'd2, 5, 12'h7FF), 32'h1, 0, 0, '0, 0, "R2 page5");
    idle();
    chk_idle("R4 idle gap");

    // R5: bypass while remapping is on
    bypass_req = 1;
    step(1, 0, mk(2'd1, 8, 12'h044), 32'hB0, 0, 0, '0, 0, "R5 bypass");
    step(1, 1, mk(2'd2, 11, 12'h055), 32'hB1, 0, 0, '0, 0, "R5 bypass");
    bypass_req = 0;
    step(1, 0, mk(2'd1, 8, 12'h044), 32'hB2, 0, 0, '0, 0, "R5 bypass released R2");

    // R6: collision returns old value, then new one
    step(1, 0, mk(2'd3, 9, 12'h100), 32'hC0, 1, 9, 2'd2, 0, "R6 collision old");
    step(1, 0, mk(2'd3, 9, 12'h100), 32'hC1, 0, 0, '0, 0, "R6 after write new");
    step(1, 1, mk(2'd0, 10, 12'h200), 32'hC2, 1, 10, 2'd3, 0, "R6 collision old");
    step(1, 1, mk(2'd0, 10, 12'h201), 32'hC3, 0, 0, '0, 0, "R6 after write new");

    // R3/R4: back-to-back varied patterns
    for (int i = 0; i < 12; i++) begin
      step(1, i[0], mk(i[1:0], 8 + (i % 4), 12'(i * 331)), 32'(i * 32'h0101_0101),
           0, 0, '0, 0, "R3 burst");
    end
    idle();
    chk_idle("R4 after burst");

    // R1/R7: reset returns to pass-through
    do_reset();
    step(1, 0, mk(2'd1, 9, 12'h333), 32'hE0, 0, 0, '0, 0, "R1 passthru after reset");
    idle();
    idle();
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R4 missing outputs got %0d pending exp 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule